// File: doc/BRIEF.md
# H-Bridge Fault and Power-Mode Supervisor

This block supervises a single H-bridge power stage. It converts a driver wake request and a regulator enable into an applied power mode. It holds each applied mode for a minimum time before it accepts another one. It combines the fault conditions into one bridge-disable output. The fault conditions are per-transistor overcurrent, die temperature, supply undervoltage and supply overvoltage. The analog comparators and the temperature sensor sit outside the block. They arrive here as flags and as a binary temperature code.

Overcurrent never latches. A flag that stays high past a deglitch window shuts the bridge for a fixed retry period, after which the bridge re-arms by itself. Thermal shutdown uses two thresholds that form a hysteresis band. Overvoltage floats the outputs for as long as its flag is high. Undervoltage outranks every other condition: it resets the supervisor's timers, mode and status, and holds the logic-reset output high. A status vector reports live conditions and event bits that stay set until software clears them.

Top module: `hbridge_guard`

## Requirements
- R1: When any bit of `ocFlag` is sampled high on more than `OC_DEG` consecutive clock edges, `bridgeOff`, `faultStat[0]` (overcurrent live) and `faultStat[4]` (overcurrent event) go high after that edge. A run of exactly `OC_DEG` high samples, or a run broken by a single low sample, causes no trip.
- R2: After an overcurrent trip, `faultStat[0]` and the fault's share of `bridgeOff` stay high for exactly `RETRY_CYC` cycles and then clear without any input. The persistence count restarts from zero, so a flag still high re-trips `OC_DEG+1` edges after the re-enable.
- R3: A temperature code strictly above `TSD_HOT` sets `faultStat[1]` (thermal live), `faultStat[5]` (thermal event) and `bridgeOff` at the next edge. The live bit holds while the code is inside the band, and clears only when the code is strictly below `TSD_HOT - TSD_HYS`. A code equal to `TSD_HOT` does not set it.
- R4: `ovFlag` is registered into `faultStat[3]` (overvoltage live) and `bridgeOff`, and it sets `faultStat[7]` (overvoltage event). The live bit clears one edge after the flag falls, and the event bit stays set.
- R5: While `uvFlag` is high, the outputs are `logicRst`=1, `bridgeOff`=1, `regOn`=0, `drvActive`=0 and `faultStat`=8'h04, one edge after the flag rises. The retry timer, dwell timer, applied mode and every event bit are cleared. On the edge where the flag is first seen low, `faultStat[6]` (undervoltage event) sets and the pending mode request is applied at once.
- R6: The applied mode is {`drvWake`, `regEn`}. `drvActive` follows `drvWake` and `regOn` follows `regEn`, one edge after the request is accepted. While `drvActive` is 0, `bridgeOff` is 1.
- R7: After a mode is applied, no new mode is applied for `DWELL_CYC` cycles. A request that changes during that window is applied on the first edge after the window closes, using only the latest request.
- R8: A high `statClr` clears the event bits `faultStat[7:4]` at the next edge. Live bits are unaffected, and an event still present on that edge keeps its bit set.
- R9: After reset: applied mode {0,0}, `bridgeOff`=1, `logicRst`=0, `regOn`=0, `drvActive`=0, `faultStat`=0.
- R10: `regOn` depends only on the regulator request. Putting the driver to sleep while the regulator is requested leaves `regOn` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| drvWake | input | 1 | Driver mode request, 1 = active, 0 = sleep |
| regEn | input | 1 | Regulator mode request, 1 = on |
| ocFlag | input | NFET | Per-transistor overcurrent comparator flags |
| dieTemp | input | TEMP_W | Die temperature code, unsigned |
| uvFlag | input | 1 | Supply undervoltage comparator flag |
| ovFlag | input | 1 | Supply overvoltage comparator flag |
| statClr | input | 1 | Clears the event bits of the status vector |
| bridgeOff | output | 1 | Forces all bridge transistors off |
| logicRst | output | 1 | Reset to the rest of the driver logic |
| regOn | output | 1 | Regulator enable as applied |
| drvActive | output | 1 | Driver awake as applied |
| faultStat | output | 8 | [3:0] live OV, UV, thermal, OC; [7:4] events OV, UV, thermal, OC |

## Verification
The bench sets `OC_DEG` to 4, `RETRY_CYC` to 20 and `DWELL_CYC` to 16, and keeps the thermal thresholds at 160 and 110 with eight-bit codes. With these short windows, the bench can reach several cases within a few dozen cycles each. It can show the exact trip edge of a sustained overcurrent, and the no-trip outcome of a pulse one edge too short. It can also observe the automatic re-enable, a second trip from a flag left high, and a mode request that changes twice inside one dwell window. The small values also let an undervoltage arrive while the retry timer and the dwell timer are both running, so the bench can confirm that both are cleared.

// File: rtl/hbg_pkg.sv
`timescale 1ns/1ps
package hbg_pkg;

  // control -> datapath strobes
  typedef struct packed {
    logic ocClr;      // drop the overcurrent persistence count
    logic retryLoad;  // start the retry period
    logic dwellLoad;  // start the mode dwell period
    logic uvClr;      // undervoltage: zero every timer
  } hbgStrobe_t;

  // datapath -> control conditions
  typedef struct packed {
    logic ocLong;     // a flag persisted past the deglitch window
    logic retryZero;  // retry timer expired
    logic dwellIdle;  // dwell timer expired
    logic tempHot;    // code above the shutdown threshold
    logic tempCool;   // code below the release threshold
  } hbgDpStat_t;

  localparam int STAT_W = 8;

endpackage

// File: rtl/hbg_dp.sv
`timescale 1ns/1ps
module hbg_dp
  import hbg_pkg::*;
#(
  parameter int NFET      = 4,
  parameter int OC_DEG    = 250,
  parameter int RETRY_CYC = 1000000,
  parameter int DWELL_CYC = 250000,
  parameter int TEMP_W    = 8,
  parameter int TSD_HOT   = 160,
  parameter int TSD_HYS   = 50
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NFET-1:0]   ocFlag,
  input  logic [TEMP_W-1:0] dieTemp,
  input  hbgStrobe_t        strb,
  output hbgDpStat_t        dpStat
);

  localparam int OCW = $clog2(OC_DEG + 1);
  localparam int RTW = $clog2(RETRY_CYC + 1);
  localparam int DWW = $clog2(DWELL_CYC + 1);
  localparam logic [OCW-1:0]    OC_LIM  = OCW'(OC_DEG);
  localparam logic [RTW-1:0]    RT_LOAD = RTW'(RETRY_CYC - 1);
  localparam logic [DWW-1:0]    DW_LOAD = DWW'(DWELL_CYC - 1);
  localparam logic [TEMP_W-1:0] HOT_T   = TEMP_W'(TSD_HOT);
  localparam logic [TEMP_W-1:0] COOL_T  = TEMP_W'(TSD_HOT - TSD_HYS);

  logic           ocAny;
  logic [OCW-1:0] ocCnt;
  logic [RTW-1:0] retryCnt;
  logic [DWW-1:0] dwellCnt;

  assign ocAny = |ocFlag;

  // persistence counter: any low sample or a control clear restarts it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  ocCnt <= '0;
    else if (strb.ocClr || !ocAny) ocCnt <= '0;
    else if (ocCnt != OC_LIM)   ocCnt <= ocCnt + OCW'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  retryCnt <= '0;
    else if (strb.uvClr)        retryCnt <= '0;
    else if (strb.retryLoad)    retryCnt <= RT_LOAD;
    else if (retryCnt != '0)    retryCnt <= retryCnt - RTW'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  dwellCnt <= '0;
    else if (strb.uvClr)        dwellCnt <= '0;
    else if (strb.dwellLoad)    dwellCnt <= DW_LOAD;
    else if (dwellCnt != '0)    dwellCnt <= dwellCnt - DWW'(1);
  end

  always_comb begin
    dpStat.ocLong    = ocAny && (ocCnt == OC_LIM);
    dpStat.retryZero = (retryCnt == '0);
    dpStat.dwellIdle = (dwellCnt == '0);
    dpStat.tempHot   = dieTemp > HOT_T;
    dpStat.tempCool  = dieTemp < COOL_T;
  end

  // R1
  oc_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    ocCnt <= OC_LIM);

endmodule

// File: rtl/hbg_ctrl.sv
`timescale 1ns/1ps
module hbg_ctrl
  import hbg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              drvWake,
  input  logic              regEn,
  input  logic              uvFlag,
  input  logic              ovFlag,
  input  logic              statClr,
  input  hbgDpStat_t        dpStat,
  output hbgStrobe_t        strb,
  output logic              bridgeOff,
  output logic              logicRst,
  output logic              regOn,
  output logic              drvActive,
  output logic [STAT_W-1:0] faultStat
);

  logic       uvQ, ovLive, tsdLive, retryActive;
  logic [1:0] modeQ, modeReq;
  logic [3:0] stickyQ, stickySet;   // [0] oc, [1] thermal, [2] uv, [3] ov
  logic       ocTrip, modeChange, tsdNext;

  assign modeReq    = {drvWake, regEn};
  assign ocTrip     = dpStat.ocLong && !retryActive && !uvFlag;
  assign modeChange = !uvFlag && dpStat.dwellIdle && (modeReq != modeQ);

  always_comb begin
    strb.ocClr     = uvFlag || retryActive || ocTrip;
    strb.retryLoad = ocTrip;
    strb.dwellLoad = modeChange;
    strb.uvClr     = uvFlag;
  end

  always_comb begin
    tsdNext = tsdLive;
    if (dpStat.tempHot)       tsdNext = 1'b1;
    else if (dpStat.tempCool) tsdNext = 1'b0;
  end

  // uvQ high with the flag now low marks the release edge
  assign stickySet = {ovFlag, uvQ, dpStat.tempHot, ocTrip};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      uvQ         <= 1'b0;
      ovLive      <= 1'b0;
      tsdLive     <= 1'b0;
      retryActive <= 1'b0;
      modeQ       <= 2'b00;
      stickyQ     <= '0;
    end else if (uvFlag) begin
      uvQ         <= 1'b1;
      ovLive      <= 1'b0;
      tsdLive     <= 1'b0;
      retryActive <= 1'b0;
      modeQ       <= 2'b00;
      stickyQ     <= '0;
    end else begin
      uvQ     <= 1'b0;
      ovLive  <= ovFlag;
      tsdLive <= tsdNext;
      if (ocTrip)                               retryActive <= 1'b1;
      else if (retryActive && dpStat.retryZero) retryActive <= 1'b0;
      if (modeChange) modeQ <= modeReq;
      stickyQ <= (statClr ? 4'b0000 : stickyQ) | stickySet;
    end
  end

  assign regOn     = modeQ[0];
  assign drvActive = modeQ[1];
  assign logicRst  = uvQ;
  assign bridgeOff = uvQ || ovLive || tsdLive || retryActive || !modeQ[1];
  assign faultStat = {stickyQ, ovLive, uvQ, tsdLive, retryActive};

  // R5
  uv_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    uvFlag |=> (logicRst && bridgeOff && !regOn && !drvActive && faultStat == 8'h04));

  // R1
  oc_trip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dpStat.ocLong && !retryActive && !uvFlag) |=> (retryActive && bridgeOff));

  // R2
  retry_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (retryActive && !dpStat.retryZero && !uvFlag) |=> retryActive);

  // R7
  dwell_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(modeQ) |-> ($past(dpStat.dwellIdle) || $past(uvFlag)));

  // R3
  tsd_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dpStat.tempHot && !uvFlag) |=> (faultStat[1] && bridgeOff));

endmodule

// File: rtl/hbridge_guard.sv
`timescale 1ns/1ps
module hbridge_guard
  import hbg_pkg::*;
#(
  parameter int NFET      = 4,
  parameter int OC_DEG    = 250,
  parameter int RETRY_CYC = 1000000,
  parameter int DWELL_CYC = 250000,
  parameter int TEMP_W    = 8,
  parameter int TSD_HOT   = 160,
  parameter int TSD_HYS   = 50
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              drvWake,
  input  logic              regEn,
  input  logic [NFET-1:0]   ocFlag,
  input  logic [TEMP_W-1:0] dieTemp,
  input  logic              uvFlag,
  input  logic              ovFlag,
  input  logic              statClr,
  output logic              bridgeOff,
  output logic              logicRst,
  output logic              regOn,
  output logic              drvActive,
  output logic [7:0]        faultStat
);

  hbgStrobe_t strb;
  hbgDpStat_t dpStat;

  hbg_dp #(
    .NFET(NFET), .OC_DEG(OC_DEG), .RETRY_CYC(RETRY_CYC), .DWELL_CYC(DWELL_CYC),
    .TEMP_W(TEMP_W), .TSD_HOT(TSD_HOT), .TSD_HYS(TSD_HYS)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ocFlag(ocFlag), .dieTemp(dieTemp),
    .strb(strb), .dpStat(dpStat)
  );

  hbg_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .drvWake(drvWake), .regEn(regEn),
    .uvFlag(uvFlag), .ovFlag(ovFlag), .statClr(statClr), .dpStat(dpStat),
    .strb(strb), .bridgeOff(bridgeOff), .logicRst(logicRst), .regOn(regOn),
    .drvActive(drvActive), .faultStat(faultStat)
  );

  // R6
  sleep_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !drvActive |-> bridgeOff);

endmodule

// File: tb/hbridge_guard_tb_top.sv
`timescale 1ns/1ps
module hbridge_guard_tb_top;

  localparam int NFET = 4;
  localparam int OCD  = 4;
  localparam int RTY  = 20;
  localparam int DWL  = 16;
  localparam int TW   = 8;

  // observation vector {bridgeOff, logicRst, regOn, drvActive, faultStat}
  localparam logic [11:0] BOFF = 12'h800, LRST = 12'h400, RGON = 12'h200, DRVA = 12'h100;
  localparam logic [11:0] OCL = 12'h001, TSL = 12'h002, UVL = 12'h004, OVL = 12'h008;
  localparam logic [11:0] OCS = 12'h010, TSS = 12'h020, UVS = 12'h040, OVS = 12'h080;
  localparam logic [11:0] ALL = 12'hFFF;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic            rstN, drvWake, regEn, uvFlag, ovFlag, statClr;
  logic [NFET-1:0] ocFlag;
  logic [TW-1:0]   dieTemp;
  logic            bridgeOff, logicRst, regOn, drvActive;
  logic [7:0]      faultStat;

  hbridge_guard #(
    .NFET(NFET), .OC_DEG(OCD), .RETRY_CYC(RTY), .DWELL_CYC(DWL),
    .TEMP_W(TW), .TSD_HOT(160), .TSD_HYS(50)
  ) dut_i (
    .clk(clk), .rstN(rstN), .drvWake(drvWake), .regEn(regEn), .ocFlag(ocFlag),
    .dieTemp(dieTemp), .uvFlag(uvFlag), .ovFlag(ovFlag), .statClr(statClr),
    .bridgeOff(bridgeOff), .logicRst(logicRst), .regOn(regOn),
    .drvActive(drvActive), .faultStat(faultStat)
  );

  wire [11:0] obs = {bridgeOff, logicRst, regOn, drvActive, faultStat};

  typedef struct {
    int          at;
    logic [11:0] mask;
    logic [11:0] val;
    string       req;
  } item_t;

  item_t q[$];
  int    cyc = 0;
  int    nChk = 0;
  int    nErr = 0;
  bit    done = 0;
  int    lastApply = -1000;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic report();
    $display("  Simulation finished: %0d checks, %0d errors", nChk, nErr);
    $finish;
  endtask

  // driver side: push an expectation for the cycle count at which it holds
  task automatic expectAt(int at, logic [11:0] mask, logic [11:0] val, string req);
    item_t it;
    int    k;
    it.at = at; it.mask = mask; it.val = val; it.req = req;
    k = q.size();
    while (k > 0 && q[k-1].at > at) k--;
    q.insert(k, it);
  endtask

  // monitor side: pop and compare when the cycle is reached
  always @(negedge clk) begin : monitor
    item_t it;
    while (q.size() > 0 && q[0].at <= cyc) begin
      it = q.pop_front();
      nChk++;
      if ((obs & it.mask) !== (it.val & it.mask)) begin
        nErr++;
        $display("FAIL %s cycle %0d: actual %h expected %h (mask %h)",
                 it.req, cyc, obs & it.mask, it.val & it.mask, it.mask);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // request a mode once the bench's own dwell bookkeeping allows it
  task automatic applyMode(logic w, logic r);
    while (cyc + 1 < lastApply + DWL) @(negedge clk);
    drvWake   = w;
    regEn     = r;
    lastApply = cyc + 1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      nErr++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      report();
    end
  end

  initial begin : driver
    int t, tr, tr2;
    rstN = 1'b0; drvWake = 1'b0; regEn = 1'b0; ocFlag = '0; dieTemp = 8'd25;
    uvFlag = 1'b0; ovFlag = 1'b0; statClr = 1'b0;
    tick(3);
    rstN = 1'b1;
    // R9 reset state
    expectAt(cyc + 1, ALL, BOFF, "R9");
    expectAt(cyc + 3, ALL, BOFF, "R9");
    tick(4);

    // R6 both requested
    applyMode(1'b1, 1'b1);
    t = lastApply;
    expectAt(t, ALL, RGON | DRVA, "R6");
    tick(1);
    // R7 requests inside the dwell window; only the last one counts
    drvWake = 1'b0; regEn = 1'b0;
    expectAt(cyc + 3, RGON | DRVA | BOFF, RGON | DRVA, "R7");
    tick(4);
    drvWake = 1'b1;
    expectAt(t + DWL - 1, RGON | DRVA, RGON | DRVA, "R7");
    expectAt(t + DWL, RGON | DRVA | BOFF, DRVA, "R7");
    tick(t + DWL - cyc);
    lastApply = t + DWL;

    // R10 regulator stays on while the driver sleeps
    applyMode(1'b1, 1'b1);
    expectAt(lastApply, RGON | DRVA, RGON | DRVA, "R10");
    applyMode(1'b0, 1'b1);
    expectAt(lastApply, RGON | DRVA | BOFF, RGON | BOFF, "R10");
    applyMode(1'b1, 1'b1);
    expectAt(lastApply, ALL, RGON | DRVA, "R6");
    tick(2);

    // R1 run of exactly OCD samples: no trip
    ocFlag = 4'b0010;
    tick(OCD);
    ocFlag = '0;
    expectAt(cyc + 2, BOFF | OCL | OCS, 12'h000, "R1");
    tick(3);
    // R1 two runs split by one low sample: no trip
    ocFlag = 4'b1000;
    tick(OCD);
    ocFlag = '0;
    tick(1);
    ocFlag = 4'b0100;
    tick(OCD);
    ocFlag = '0;
    expectAt(cyc + 2, BOFF | OCL | OCS, 12'h000, "R1");
    tick(3);

    // R1 sustained flag trips on edge OCD+1
    ocFlag = 4'b0001;
    tr = cyc + OCD + 1;
    expectAt(tr - 1, BOFF | OCL, 12'h000, "R1");
    expectAt(tr, BOFF | OCL | OCS, BOFF | OCL | OCS, "R1");
    // R2 retry length, then a re-trip with the flag still high
    expectAt(tr + RTY - 1, BOFF | OCL, BOFF | OCL, "R2");
    expectAt(tr + RTY, BOFF | OCL, 12'h000, "R2");
    tr2 = tr + RTY + OCD + 1;
    expectAt(tr2 - 1, OCL, 12'h000, "R2");
    expectAt(tr2, BOFF | OCL, BOFF | OCL, "R2");
    tick(tr2 - cyc);
    ocFlag = '0;
    expectAt(tr2 + RTY - 1, OCL, OCL, "R2");
    expectAt(tr2 + RTY, ALL, RGON | DRVA | OCS, "R2");
    tick(tr2 + RTY + 1 - cyc);

    // R8 clear event bits
    statClr = 1'b1;
    expectAt(cyc + 1, ALL, RGON | DRVA, "R8");
    tick(1);
    statClr = 1'b0;
    tick(1);

    // R3 thermal thresholds
    dieTemp = 8'd160;
    expectAt(cyc + 1, BOFF | TSL | TSS, 12'h000, "R3");
    tick(2);
    dieTemp = 8'd161;
    expectAt(cyc + 1, BOFF | TSL | TSS, BOFF | TSL | TSS, "R3");
    tick(2);
    dieTemp = 8'd110;
    expectAt(cyc + 2, BOFF | TSL, BOFF | TSL, "R3");
    tick(3);
    dieTemp = 8'd109;
    expectAt(cyc + 1, BOFF | TSL | TSS, TSS, "R3");
    tick(2);

    // R4 overvoltage
    ovFlag = 1'b1;
    expectAt(cyc + 1, BOFF | OVL | OVS, BOFF | OVL | OVS, "R4");
    tick(2);
    // R8 clear while overvoltage is still present
    statClr = 1'b1;
    expectAt(cyc + 1, OVL | OVS | TSS, OVL | OVS, "R8");
    tick(1);
    statClr = 1'b0;
    ovFlag  = 1'b0;
    expectAt(cyc + 1, BOFF | OVL | OVS, OVS, "R4");
    tick(2);

    // R5 undervoltage during a dwell window and a retry period
    applyMode(1'b1, 1'b0);
    ocFlag = 4'b0010;
    tick(OCD + 1);
    ocFlag = '0;
    uvFlag = 1'b1; drvWake = 1'b1; regEn = 1'b1;
    expectAt(cyc + 1, ALL, BOFF | LRST | UVL, "R5");
    tick(3);
    uvFlag = 1'b0;
    expectAt(cyc + 1, ALL, RGON | DRVA | UVS, "R5");
    lastApply = cyc + 1;
    tick(4);

    done = 1'b1;
    report();
  end

endmodule